// File: doc/BRIEF.md
# Audio Overload Flag Stretcher

This block sits behind the decimator of a stereo audio ADC and watches the left and right PCM words it produces. A sample is in overload when its magnitude rises above a fixed level just under digital full scale, roughly 1.16 dB below the largest swing. When either channel overloads, the block raises a single flag. The flag then stays up for a long, retriggerable hold window, so that slow record-level logic or an indicator can see even a single clipped sample.

The hold window is counted in sample periods, not clock cycles. The counter moves only on the sample-valid strobe, so the visible hold time follows the sample rate. With the default length of 512 samples at 44.1 kHz, the hold is about 11.6 ms. Each new over-level sample reloads the window to its full length.

Top module: `audio_peak_hold`

## Requirements
- R1: After a synchronous active-high reset, the flag is low. It stays low while every strobed sample is within the level.
- R2: A strobed sample in two's complement whose positive value is strictly greater than THRESH (default 7,339,000 for 24-bit samples) counts as an overload.
- R3: A negative sample whose absolute value exceeds THRESH counts as an overload. The most negative code (-2^23 by default) always counts as an overload.
- R4: A sample whose magnitude equals THRESH exactly is not an overload. This holds for both +THRESH and -THRESH.
- R5: An overload on the left channel alone, or on the right channel alone, is enough to raise the flag.
- R6: The flag is high in the clock cycle after the edge on which the strobe carried the overloading sample. Samples presented while the strobe is low have no effect.
- R7: After an overload strobe, the flag stays high through the next HOLD_LEN-1 strobes that carry no overload. It goes low after the HOLD_LEN-th such strobe (default HOLD_LEN = 512).
- R8: An overload strobe that arrives while the flag is already high restarts the hold window from its full length.
- R9: Clock cycles without a strobe neither shorten nor extend the hold window.
- R10: Asserting reset during a hold window drops the flag on the next clock edge. The next window then begins only at a fresh overload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe marking a new stereo sample pair |
| smp_left | input | SAMPLE_W | Left sample, signed two's complement |
| smp_right | input | SAMPLE_W | Right sample, signed two's complement |
| peak_flag | output | 1 | Registered overload flag, stretched over the hold window |

## Verification
The hardest cases to reach from the ports are the exact end of a hold window and a reload that lands late in a running window. Reaching either needs hundreds of strobes, laid out exactly, with idle clocks mixed in. The stimulus counts out 511 and then 512 clean strobes after a hit, with idle cycles that carry large samples in between. It then retriggers 300 strobes into a window, using the most negative code, and checks that the window is extended to the full length again. A long pseudo-random phase follows, compared against a behavioural count model on every clock.

// File: rtl/audio_peak_pkg.sv
package audio_peak_pkg;

  // Number of audio channels watched in parallel.
  localparam int CH_COUNT = 2;

  // Unsigned magnitude of a 32-bit signed value.
  // The extra bit lets the most negative code map to 2^31.
  function automatic logic [32:0] mag33(input logic signed [31:0] s);
    logic [32:0] ext;
    ext = {s[31], s};
    if (s[31]) mag33 = ~ext + 33'd1;
    else       mag33 = ext;
  endfunction

  // Overload test: strictly above the level.
  function automatic logic exceeds(input logic signed [31:0] s, input int unsigned lvl);
    exceeds = mag33(s) > {1'b0, 32'(lvl)};
  endfunction

endpackage

// File: rtl/peak_level_cmp.sv
module peak_level_cmp #(
  parameter int SAMPLE_W = 24,
  parameter int THRESH   = 7339000
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       over
);
  import audio_peak_pkg::*;

  // Sign-extend to the package's working width (SAMPLE_W <= 32).
  logic signed [31:0] wide;
  assign wide = 32'(sample);
  assign over = exceeds(wide, THRESH);

endmodule

// File: rtl/peak_hold_timer.sv
module peak_hold_timer #(
  parameter int HOLD_LEN = 512,
  localparam int CNT_W   = $clog2(HOLD_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,   // sample strobe
  input  logic             load,   // strobe carrying an overload
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (load) begin
      cnt  <= CNT_W'(HOLD_LEN);
      flag <= 1'b1;
    end else if (step && cnt != '0) begin
      cnt  <= cnt - 1'b1;
      flag <= (cnt != CNT_W'(1));
    end
  end

endmodule

// File: rtl/audio_peak_hold.sv
module audio_peak_hold #(
  parameter int SAMPLE_W = 24,
  parameter int THRESH   = 7339000,
  parameter int HOLD_LEN = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp_left,
  input  logic signed [SAMPLE_W-1:0] smp_right,
  output logic                       peak_flag
);
  import audio_peak_pkg::*;

  localparam int CNT_W = $clog2(HOLD_LEN + 1);

  logic signed [SAMPLE_W-1:0] chan_smp [CH_COUNT];
  logic [CH_COUNT-1:0]        chan_over;
  logic                       hit_any;
  logic                       hold_load;
  logic [CNT_W-1:0]           hold_cnt;

  assign chan_smp[0] = smp_left;
  assign chan_smp[1] = smp_right;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    peak_level_cmp #(.SAMPLE_W(SAMPLE_W), .THRESH(THRESH)) u_cmp (
      .sample (chan_smp[c]),
      .over   (chan_over[c])
    );
  end

  assign hit_any   = |chan_over;
  assign hold_load = smp_vld & hit_any;

  peak_hold_timer #(.HOLD_LEN(HOLD_LEN)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .step (smp_vld),
    .load (hold_load),
    .cnt  (hold_cnt),
    .flag (peak_flag)
  );

endmodule

// File: rtl/peak_hold_chk.sv
module peak_hold_chk #(
  parameter int HOLD_LEN = 512,
  parameter int CNT_W    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             vld,
  input logic             hit,
  input logic             flag,
  input logic [CNT_W-1:0] cnt
);

  // R6
  rise_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    vld && hit |=> flag);

  // R8
  reload_full_chk: assert property (@(posedge clk) disable iff (rst)
    vld && hit |=> cnt == CNT_W'(HOLD_LEN));

  // R9
  idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(flag) && $stable(cnt));

  // R7
  fall_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> ($past(vld) && !$past(hit)) || $past(rst));

  // R1
  empty_low_chk: assert property (@(posedge clk) disable iff (rst)
    cnt == '0 |-> !flag);

endmodule

bind audio_peak_hold peak_hold_chk #(.HOLD_LEN(HOLD_LEN), .CNT_W(CNT_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .vld  (smp_vld),
  .hit  (hit_any),
  .flag (peak_flag),
  .cnt  (hold_cnt)
);

// File: tb/sim_audio_peak_hold.sv
`timescale 1ns/1ps
module sim_audio_peak_hold;
  localparam int W    = 24;
  localparam int TH   = 7339000;
  localparam int HOLD = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic signed [W-1:0] l = '0;
  logic signed [W-1:0] r = '0;
  logic flag;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  audio_peak_hold #(.SAMPLE_W(W), .THRESH(TH), .HOLD_LEN(HOLD)) u0 (
    .clk(clk), .rst(rst), .smp_vld(vld), .smp_left(l), .smp_right(r), .peak_flag(flag)
  );

  // Behavioural reference: remaining strobes in the window.
  int ref_left = 0;
  bit ref_flag = 1'b0;

  function automatic bit too_loud(input logic signed [W-1:0] s);
    longint v;
    v = s;
    if (v < 0) v = -v;
    return v > TH;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ref_left = 0;
      ref_flag = 1'b0;
    end else if (vld) begin
      if (too_loud(l) || too_loud(r)) ref_left = HOLD;
      else if (ref_left > 0) ref_left = ref_left - 1;
      ref_flag = (ref_left > 0);
    end
  end

  // Every-clock comparison against the model (R7 window behaviour).
  always begin
    @(posedge clk);
    #1;
    if (!done) begin
      checks++;
      if (flag !== ref_flag) begin
        errs++;
        $display("FAIL R7 cycle model: actual=%b expected=%b at %0t", flag, ref_flag, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one cycle of input, return just after the edge that takes it.
  task automatic cyc(input logic v, input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    @(negedge clk);
    vld = v; l = a; r = b;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet_strobes(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 24'sd1000, -24'sd1000);
      if (i % 3 == 0) cyc(1'b0, 24'sh800000, 24'sh7FFFFF);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) cyc(1'b0, '0, '0);
    chk("R1 reset low", flag, 1'b0);
    @(negedge clk) rst = 1'b0;
    cyc(1'b1, 24'sd5000, -24'sd7000000);
    cyc(1'b1, 24'sd7338999, 24'sd0);
    chk("R1 quiet stays low", flag, 1'b0);

    cyc(1'b1, 24'(TH), 24'(TH));
    chk("R4 equal +level", flag, 1'b0);
    cyc(1'b1, -24'(TH), -24'(TH));
    chk("R4 equal -level", flag, 1'b0);

    cyc(1'b0, 24'(TH + 1), 24'sh800000);
    chk("R6 unstrobed ignored", flag, 1'b0);

    cyc(1'b1, 24'(TH + 1), 24'sd0);
    chk("R2 R5 R6 left positive hit", flag, 1'b1);

    quiet_strobes(HOLD - 1);
    chk("R7 R9 still high at last strobe", flag, 1'b1);
    cyc(1'b0, '0, '0);
    chk("R9 idle keeps", flag, 1'b1);
    cyc(1'b1, '0, '0);
    chk("R7 drops after full window", flag, 1'b0);

    cyc(1'b1, 24'sd0, -24'(TH + 1));
    chk("R3 R5 right negative hit", flag, 1'b1);
    quiet_strobes(300);
    cyc(1'b1, 24'sh800000, 24'sd0);
    chk("R3 most negative code", flag, 1'b1);
    quiet_strobes(HOLD - 1);
    chk("R8 retrigger extends", flag, 1'b1);
    cyc(1'b1, '0, '0);
    chk("R8 ends full length after reload", flag, 1'b0);

    cyc(1'b1, 24'sh7FFFFF, 24'sd0);
    quiet_strobes(10);
    @(negedge clk) rst = 1'b1;
    @(posedge clk) #1;
    chk("R10 reset mid window", flag, 1'b0);
    @(negedge clk) rst = 1'b0;
    quiet_strobes(5);
    chk("R10 no resume after reset", flag, 1'b0);

    for (int i = 0; i < 20000; i++) begin
      logic [31:0] rnd;
      logic signed [W-1:0] a;
      logic signed [W-1:0] b;
      rnd = $urandom;
      a = (rnd[7:0] == 8'd0) ? 24'($urandom) : 24'(int'($urandom % 2000000) - 1000000);
      b = (rnd[15:8] == 8'd1) ? 24'($urandom) : 24'(int'($urandom % 2000000) - 1000000);
      cyc(rnd[16] | rnd[17], a, b);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule